// File: doc/BRIEF.md
# Delay-Slot Branch Resolver

This block holds the fetch program counter of a pipeline with one architectural delay slot. It decides where fetch goes after each issued instruction. Each cycle where `issue_vld` is high, one instruction issues from the address on `fetch_pc`, along with its control-transfer kind, a signed word offset, a register operand and the current condition flag. A taken transfer does not redirect fetch at once. The resolver stores the destination, lets the next sequential instruction issue as the delay slot, and only then loads the stored destination into `fetch_pc`. Call forms produce a one-cycle link-register write whose value is the call address plus 8, so that a return lands after the delay slot.

A return-from-exception kind moves `fetch_pc` straight to the saved exception address and produces a one-cycle status write carrying the saved status copy. It has no delay slot. Any control-transfer kind issued inside a delay slot raises `slot_err` for one cycle and is otherwise discarded.

Control is a two-state machine. In `ST_SEQ`, fetch advances one word per issue. A taken branch or any jump takes the transition `SEQ_TO_SLOT`. In `ST_SLOT`, a destination is pending. The next issue takes the transition `SLOT_TO_SEQ`, which loads the pending destination. Without an issue, both states hold.

Top module: `delay_slot_branch_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `fetch_pc` equals RESET_PC (default 0x100), `in_slot` is 0, and `link_we`, `status_we` and `slot_err` are 0.
- R2: `kind` encodes 0 none, 1 branch-if-flag, 2 branch-if-not-flag, 3 relative jump, 4 relative call, 5 register jump, 6 register call, 7 return-from-exception. Kind 1 is taken when `flag` is 1, and kind 2 is taken when `flag` is 0. A taken branch sets `in_slot` in the cycle after issue.
- R3: For kinds 1–4, the destination is the issuing `fetch_pc` plus the sign-extended `offset` times 4. Backward offsets are allowed.
- R4: For kinds 5 and 6, the destination is `reg_tgt` unchanged.
- R5: After a taken transfer at address A, the next `fetch_pc` is A+4 (the delay slot). When that slot instruction issues, `fetch_pc` becomes the stored destination and `in_slot` returns to 0.
- R6: A not-taken branch or kind 0 leaves `in_slot` at 0 and advances `fetch_pc` by 4.
- R7: Kinds 4 and 6 issued at address A give, in the next cycle, a single-cycle `link_we` with `link_idx` = LINK_IDX (default 9) and `link_data` = A+8.
- R8: Kind 7 loads `fetch_pc` with `saved_epc` in the next cycle, without a delay slot. It also pulses `status_we` once with `status_data` equal to `saved_status`.
- R9: Any nonzero kind issued while `in_slot` is 1 pulses `slot_err` in the next cycle. It causes no link or status write, and fetch still goes to the pending destination.
- R10: With `issue_vld` low, `fetch_pc` and `in_slot` keep their values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction issues from `fetch_pc` this cycle |
| kind | input | 3 | Control-transfer kind of the issuing instruction |
| offset | input | OFFW (26) | Signed word offset for relative forms |
| reg_tgt | input | AW (32) | Register operand for register forms |
| flag | input | 1 | Condition flag |
| saved_epc | input | AW (32) | Saved exception return address |
| saved_status | input | STW (16) | Saved status copy |
| fetch_pc | output | AW (32) | Address of the next instruction to issue |
| in_slot | output | 1 | The next issue is a delay slot |
| link_we | output | 1 | Link register write strobe |
| link_idx | output | LIDXW (5) | Link register index |
| link_data | output | AW (32) | Link value |
| status_we | output | 1 | Status restore strobe |
| status_data | output | STW (16) | Status value to restore |
| slot_err | output | 1 | Transfer found inside a delay slot |

## Verification
The hardest situation to reach is a second transfer inside a delay slot. It can only be set up by a taken transfer directly before it. The same applies to a slot held open over idle cycles. The stimulus issues a jump, deliberately issues a call as the very next instruction, and checks that no link pulse appears while fetch still reaches the first jump's destination. A separate sequence holds `issue_vld` low for several cycles between a jump and its slot, with a transfer kind driven on the idle inputs.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    typedef enum logic [2:0] {
        BRK_NONE = 3'd0,
        BRK_BF   = 3'd1,
        BRK_BNF  = 3'd2,
        BRK_J    = 3'd3,
        BRK_JAL  = 3'd4,
        BRK_JR   = 3'd5,
        BRK_JALR = 3'd6,
        BRK_RFE  = 3'd7
    } brk_kind_e;

    typedef enum logic {
        ST_SEQ  = 1'b0,
        ST_SLOT = 1'b1
    } dsb_state_e;
endpackage

// File: rtl/dsb_decode.sv
module dsb_decode
    import dsb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 26
) (
    input  brk_kind_e         kind,
    input  logic              flag,
    input  logic [AW-1:0]     pc,
    input  logic [OFFW-1:0]   offset,
    input  logic [AW-1:0]     reg_tgt,
    output logic              is_cti,
    output logic              redirect,
    output logic              is_call,
    output logic              is_rfe,
    output logic [AW-1:0]     target
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] off_ext;
    logic [AW-1:0] rel_tgt;

    assign off_ext = {{EXTW{offset[OFFW-1]}}, offset};
    assign rel_tgt = pc + (off_ext << 2);

    always_comb begin
        redirect = 1'b0;
        is_call  = 1'b0;
        target   = rel_tgt;
        unique case (kind)
            BRK_NONE: ;
            BRK_BF:   redirect = flag;
            BRK_BNF:  redirect = ~flag;
            BRK_J:    redirect = 1'b1;
            BRK_JAL:  begin redirect = 1'b1; is_call = 1'b1; end
            BRK_JR:   begin redirect = 1'b1; target = reg_tgt; end
            BRK_JALR: begin redirect = 1'b1; is_call = 1'b1; target = reg_tgt; end
            BRK_RFE:  ;
        endcase
    end

    assign is_cti = (kind != BRK_NONE);
    assign is_rfe = (kind == BRK_RFE);
endmodule

// File: rtl/dsb_fsm.sv
module dsb_fsm
    import dsb_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          STW      = 16,
    parameter logic [31:0] RESET_PC = 32'h100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_vld,
    input  logic           is_cti,
    input  logic           redirect,
    input  logic           is_call,
    input  logic           is_rfe,
    input  logic [AW-1:0]  target,
    input  logic [AW-1:0]  saved_epc,
    input  logic [STW-1:0] saved_status,
    output logic [AW-1:0]  pc_q,
    output logic [AW-1:0]  pend_q,
    output logic           in_slot,
    output logic           link_we,
    output logic [AW-1:0]  link_data,
    output logic           status_we,
    output logic [STW-1:0] status_data,
    output logic           slot_err
);
    localparam logic [AW-1:0] STEP  = AW'(4);
    localparam logic [AW-1:0] SKIP  = AW'(8);
    localparam logic [AW-1:0] PC_RV = AW'(RESET_PC);

    dsb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:  if (issue_vld && redirect) state_d = ST_SLOT;
            ST_SLOT: if (issue_vld)             state_d = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEQ;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= PC_RV;
            pend_q      <= '0;
            link_we     <= 1'b0;
            link_data   <= '0;
            status_we   <= 1'b0;
            status_data <= '0;
            slot_err    <= 1'b0;
        end else begin
            link_we   <= 1'b0;
            status_we <= 1'b0;
            slot_err  <= 1'b0;
            if (issue_vld) begin
                unique case (state_q)
                    ST_SEQ: begin
                        if (is_rfe) begin
                            pc_q        <= saved_epc;
                            status_we   <= 1'b1;
                            status_data <= saved_status;
                        end else begin
                            pc_q <= pc_q + STEP;
                        end
                        if (redirect) pend_q <= target;
                        if (is_call) begin
                            link_we   <= 1'b1;
                            link_data <= pc_q + SKIP;
                        end
                    end
                    ST_SLOT: begin
                        pc_q     <= pend_q;
                        slot_err <= is_cti;
                    end
                endcase
            end
        end
    end

    assign in_slot = (state_q == ST_SLOT);
endmodule

// File: rtl/delay_slot_branch_unit.sv
module delay_slot_branch_unit
    import dsb_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          OFFW     = 26,
    parameter int          STW      = 16,
    parameter int          LIDXW    = 5,
    parameter int          LINK_IDX = 9,
    parameter logic [31:0] RESET_PC = 32'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [2:0]       kind,
    input  logic [OFFW-1:0]  offset,
    input  logic [AW-1:0]    reg_tgt,
    input  logic             flag,
    input  logic [AW-1:0]    saved_epc,
    input  logic [STW-1:0]   saved_status,
    output logic [AW-1:0]    fetch_pc,
    output logic             in_slot,
    output logic             link_we,
    output logic [LIDXW-1:0] link_idx,
    output logic [AW-1:0]    link_data,
    output logic             status_we,
    output logic [STW-1:0]   status_data,
    output logic             slot_err
);
    logic          d_cti, d_redirect, d_call, d_rfe;
    logic [AW-1:0] d_target;
    logic [AW-1:0] pend_tgt;

    dsb_decode #(.AW(AW), .OFFW(OFFW)) u_dec (
        .kind     (brk_kind_e'(kind)),
        .flag     (flag),
        .pc       (fetch_pc),
        .offset   (offset),
        .reg_tgt  (reg_tgt),
        .is_cti   (d_cti),
        .redirect (d_redirect),
        .is_call  (d_call),
        .is_rfe   (d_rfe),
        .target   (d_target)
    );

    dsb_fsm #(.AW(AW), .STW(STW), .RESET_PC(RESET_PC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_vld    (issue_vld),
        .is_cti       (d_cti),
        .redirect     (d_redirect),
        .is_call      (d_call),
        .is_rfe       (d_rfe),
        .target       (d_target),
        .saved_epc    (saved_epc),
        .saved_status (saved_status),
        .pc_q         (fetch_pc),
        .pend_q       (pend_tgt),
        .in_slot      (in_slot),
        .link_we      (link_we),
        .link_data    (link_data),
        .status_we    (status_we),
        .status_data  (status_data),
        .slot_err     (slot_err)
    );

    assign link_idx = LIDXW'(LINK_IDX);
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
    import dsb_pkg::*;
#(
    parameter int AW  = 32,
    parameter int STW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           issue_vld,
    input logic [2:0]     kind,
    input logic           flag,
    input logic [AW-1:0]  saved_epc,
    input logic [STW-1:0] saved_status,
    input logic [AW-1:0]  fetch_pc,
    input logic [AW-1:0]  pend_tgt,
    input logic           in_slot,
    input logic           link_we,
    input logic [AW-1:0]  link_data,
    input logic           status_we,
    input logic [STW-1:0] status_data,
    input logic           slot_err
);
    // R7
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == $past(fetch_pc) + AW'(8)));

    // R5
    slot_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && issue_vld) |=> (!in_slot && fetch_pc == $past(pend_tgt)));

    // R9
    slot_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> (!link_we && !status_we && !in_slot));

    // R6
    not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !in_slot && kind == 3'd1 && !flag)
        |=> (!in_slot && fetch_pc == $past(fetch_pc) + AW'(4)));

    // R8
    rfe_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> (fetch_pc == $past(saved_epc) && status_data == $past(saved_status)
                       && !in_slot));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> ($stable(fetch_pc) && $stable(in_slot)));
endmodule

bind delay_slot_branch_unit dsb_checker #(.AW(AW), .STW(STW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_vld    (issue_vld),
    .kind         (kind),
    .flag         (flag),
    .saved_epc    (saved_epc),
    .saved_status (saved_status),
    .fetch_pc     (fetch_pc),
    .pend_tgt     (pend_tgt),
    .in_slot      (in_slot),
    .link_we      (link_we),
    .link_data    (link_data),
    .status_we    (status_we),
    .status_data  (status_data),
    .slot_err     (slot_err)
);

// File: tb/delay_slot_branch_unit_tb.sv
module delay_slot_branch_unit_tb;
    localparam int AW = 32;
    localparam int OFFW = 26;
    localparam int STW = 16;
    localparam int NV = 15;

    typedef struct packed {
        logic [2:0]      k;
        logic [OFFW-1:0] off;
        logic [AW-1:0]   rt;
        logic            fl;
        logic [AW-1:0]   exp_pc;
        logic [AW-1:0]   exp_link;   // 0: no link write expected
        logic            exp_slot;
    } vec_t;

    // Kinds: 0 none,1 bf,2 bnf,3 j,4 jal,5 jr,6 jalr,7 rfe
    localparam vec_t TBL [NV] = '{
        '{3'd0, 26'd0,       32'h0,    1'b0, 32'h104,  32'h0,    1'b0}, // R6
        '{3'd1, 26'd4,       32'h0,    1'b1, 32'h108,  32'h0,    1'b1}, // R2 forward
        '{3'd0, 26'd0,       32'h0,    1'b0, 32'h114,  32'h0,    1'b0}, // R5 R3
        '{3'd1, 26'd8,       32'h0,    1'b0, 32'h118,  32'h0,    1'b0}, // R6 not taken
        '{3'd2, 26'h3FFFFFE, 32'h0,    1'b0, 32'h11C,  32'h0,    1'b1}, // R2 backward
        '{3'd0, 26'd0,       32'h0,    1'b0, 32'h110,  32'h0,    1'b0}, // R3 backward
        '{3'd2, 26'd3,       32'h0,    1'b1, 32'h114,  32'h0,    1'b0}, // R6
        '{3'd3, 26'h3FFFFFB, 32'h0,    1'b0, 32'h118,  32'h0,    1'b1}, // R3 jump
        '{3'd0, 26'd0,       32'h0,    1'b0, 32'h100,  32'h0,    1'b0}, // R5
        '{3'd5, 26'd7,       32'h2000, 1'b0, 32'h104,  32'h0,    1'b1}, // R4
        '{3'd0, 26'd0,       32'h0,    1'b0, 32'h2000, 32'h0,    1'b0}, // R4
        '{3'd4, 26'h10,      32'h0,    1'b0, 32'h2004, 32'h2008, 1'b1}, // R7
        '{3'd0, 26'd0,       32'h0,    1'b0, 32'h2040, 32'h0,    1'b0}, // R7 R3
        '{3'd6, 26'd0,       32'h300,  1'b1, 32'h2044, 32'h2048, 1'b1}, // R7 R4
        '{3'd0, 26'd0,       32'h0,    1'b0, 32'h300,  32'h0,    1'b0}  // R5
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue_vld = 1'b0;
    logic [2:0]       kind = '0;
    logic [OFFW-1:0]  offset = '0;
    logic [AW-1:0]    reg_tgt = '0;
    logic             flag = 1'b0;
    logic [AW-1:0]    saved_epc = '0;
    logic [STW-1:0]   saved_status = '0;
    logic [AW-1:0]    fetch_pc;
    logic             in_slot;
    logic             link_we;
    logic [4:0]       link_idx;
    logic [AW-1:0]    link_data;
    logic             status_we;
    logic [STW-1:0]   status_data;
    logic             slot_err;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    delay_slot_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .kind(kind),
        .offset(offset), .reg_tgt(reg_tgt), .flag(flag), .saved_epc(saved_epc),
        .saved_status(saved_status), .fetch_pc(fetch_pc), .in_slot(in_slot),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
        .status_we(status_we), .status_data(status_data), .slot_err(slot_err)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] k, input logic [OFFW-1:0] o,
                         input logic [AW-1:0] r, input logic f);
        issue_vld = v; kind = k; offset = o; reg_tgt = r; flag = f;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (400) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", fetch_pc, 32'h100);
        chk("R1 slot in reset", {31'b0, in_slot}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after reset", fetch_pc, 32'h100);
        chk("R1 pulses after reset", {29'b0, link_we, status_we, slot_err}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, TBL[i].k, TBL[i].off, TBL[i].rt, TBL[i].fl);
            chk("R2/R3/R4/R5/R6 pc", fetch_pc, TBL[i].exp_pc);
            chk("R2/R5 in_slot", {31'b0, in_slot}, {31'b0, TBL[i].exp_slot});
            chk("R7 link_we", {31'b0, link_we}, {31'b0, (TBL[i].exp_link != 0)});
            if (TBL[i].exp_link != 0) begin
                chk("R7 link_data", link_data, TBL[i].exp_link);
                chk("R7 link_idx", {27'b0, link_idx}, 32'd9);
            end
        end

        // R8: return from exception at 0x300
        saved_epc = 32'h5A0; saved_status = 16'h1234;
        drive(1'b1, 3'd7, 26'd0, 32'h0, 1'b0);
        chk("R8 pc", fetch_pc, 32'h5A0);
        chk("R8 status_we", {31'b0, status_we}, 32'h1);
        chk("R8 status_data", {16'b0, status_data}, 32'h1234);
        chk("R8 no slot", {31'b0, in_slot}, 32'h0);

        // R9: call inside a delay slot
        drive(1'b1, 3'd3, 26'd2, 32'h0, 1'b0);
        chk("R9 slot pc", fetch_pc, 32'h5A4);
        drive(1'b1, 3'd4, 26'd40, 32'h0, 1'b0);
        chk("R9 slot_err", {31'b0, slot_err}, 32'h1);
        chk("R9 no link", {31'b0, link_we}, 32'h0);
        chk("R9 pc to pending", fetch_pc, 32'h5A8);
        chk("R9 slot cleared", {31'b0, in_slot}, 32'h0);
        drive(1'b0, 3'd0, 26'd0, 32'h0, 1'b0);
        chk("R9 pulse single", {31'b0, slot_err}, 32'h0);

        // R10: idle with a jump kind on the inputs, in both states
        for (int j = 0; j < 3; j++) begin
            drive(1'b0, 3'd3, 26'd100, 32'h0, 1'b1);
            chk("R10 idle pc seq", fetch_pc, 32'h5A8);
            chk("R10 idle slot seq", {31'b0, in_slot}, 32'h0);
        end
        drive(1'b1, 3'd1, 26'h3FFFFFC, 32'h0, 1'b1);
        chk("R2 taken backward", fetch_pc, 32'h5AC);
        for (int j = 0; j < 3; j++) begin
            drive(1'b0, 3'd5, 26'd0, 32'hDEAD0, 1'b0);
            chk("R10 idle pc slot", fetch_pc, 32'h5AC);
            chk("R10 idle slot held", {31'b0, in_slot}, 32'h1);
        end
        drive(1'b1, 3'd0, 26'd0, 32'h0, 1'b0);
        chk("R5 after held slot", fetch_pc, 32'h598);
        chk("R5 slot cleared", {31'b0, in_slot}, 32'h0);

        // R1: reset mid-slot
        drive(1'b1, 3'd3, 26'd9, 32'h0, 1'b0);
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 26'd0, 32'h0, 1'b0);
        chk("R1 re-reset pc", fetch_pc, 32'h100);
        chk("R1 re-reset slot", {31'b0, in_slot}, 32'h0);
        finish_run();
    end
endmodule